// File: doc/BRIEF.md
# Calendar Alarm Match Controller

This block watches the current calendar time and decides when an alarm occurs. It receives six BCD time bytes from the timekeeping counters: seconds, minutes, hours, date, month and day of week. It also receives six alarm bytes of the same layout. The top bit of each alarm byte is that field's own enable. When every enabled field equals the current time on a one-second tick, the block raises an alarm flag and drives an active-low interrupt line.

Two interrupt modes are supported. In latched mode the interrupt line follows the flag and stays low until software clears the flag. In pulsed mode every match produces a fixed-length low pulse, so the alarm keeps recurring, for example hourly or daily. Software clears the flag in one of two ways. It can write a zero to the flag bit of the status register. If auto-clear is enabled, it can simply read the status register.

Top module: `alarm_match_ctrl`

## Requirements
- R1: After reset, flag_o is 0 and irq_no is 1.
- R2: Field index f of time_i and alm_i selects the field: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week. Bit 7 of an alarm byte enables that field. Bits 6:0 are compared as raw BCD. Bit 7 of the time byte never affects the comparison. For example, minutes alarm B0h means "minute 30, enabled".
- R3: A match occurs only in a cycle with tick_i high, at least one field enabled, and every enabled field equal. A cycle without tick_i, or with no field enabled, never matches.
- R4: No match occurs while alarm_en_i is 0 or fout_en_i is 1.
- R5: A match sets flag_o in the next cycle. While pulse_mode_i is 0, irq_no equals the inverse of flag_o, so it stays low until the flag is cleared.
- R6: While pulse_mode_i is 1, a match drives irq_no low for exactly PULSE_LEN cycles (default 16), starting in the next cycle. A new match during a pulse restarts the pulse at full length.
- R7: stat_wr_i with stat_wdata_i = 0 clears flag_o in the next cycle. stat_wr_i with stat_wdata_i = 1 leaves the flag unchanged.
- R8: stat_rd_i clears flag_o in the next cycle when auto_clr_i is 1. It has no effect when auto_clr_i is 0.
- R9: A match in the same cycle as a clear request wins, so flag_o is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second tick, high for one cycle after the time bytes update |
| time_i | input | 6x8 | Current BCD time bytes, indexed by field |
| alm_i | input | 6x8 | Alarm bytes; bit 7 is the field enable, bits 6:0 are the BCD value |
| alarm_en_i | input | 1 | Alarm function enable |
| fout_en_i | input | 1 | Frequency output enabled; blocks alarms while set |
| pulse_mode_i | input | 1 | 0 selects latched mode, 1 selects pulsed mode |
| auto_clr_i | input | 1 | Allows a status read to clear the flag |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | 1 | Value written to the flag bit |
| stat_rd_i | input | 1 | Status register read strobe |
| flag_o | output | 1 | Alarm flag |
| irq_no | output | 1 | Interrupt output, active low |

## Verification
Several internal faults show up at the ports one cycle after the tick. A wrong match decision, such as a mask that includes bit 7 or a disabled field that is still compared, appears as a wrong flag_o. A flag stuck by a broken clear path appears one cycle after the write or read strobe. A wrong pulse counter is different. It surfaces on irq_no only at the end of the pulse, up to PULSE_LEN cycles after the match. It also surfaces when a retrigger fails to extend the pulse. Because the reference model is compared on every clock, each of these faults is caught in the first cycle in which it becomes visible.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int BYTE_W     = 8;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_DOW   = 3'd5
  } field_e;
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] alm_i,
  input  logic [W-1:0] time_i,
  output logic         en_o,
  output logic         eq_o
);
  localparam logic [W-1:0] VAL_MASK = {1'b0, {(W-1){1'b1}}};

  assign en_o = alm_i[W-1];
  // enable bit and time MSB masked out
  assign eq_o = ((alm_i ^ time_i) & VAL_MASK) == '0;
endmodule

// File: rtl/alarm_flag_ctrl.sv
module alarm_flag_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;   // set wins over clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  p_flag_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  p_flag_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && clr_i) |=> !flag_q);
  p_no_spurious_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !flag_q) |=> !flag_q);
endmodule

// File: rtl/alarm_irq_gen.sv
module alarm_irq_gen #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic pulse_mode_i,
  input  logic flag_i,
  output logic irq_no
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (trig_i && pulse_mode_i) cnt_q <= LOAD;
    else if (cnt_q != '0)            cnt_q <= cnt_q - 1'b1;
  end

  assign irq_no = pulse_mode_i ? (cnt_q == '0) : !flag_i;

  p_pulse_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && pulse_mode_i) |=> (cnt_q == LOAD));
  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD);
endmodule

// File: rtl/alarm_match_ctrl.sv
module alarm_match_ctrl
  import alarm_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              tick_i,
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] time_i,
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] alm_i,
  input  logic                              alarm_en_i,
  input  logic                              fout_en_i,
  input  logic                              pulse_mode_i,
  input  logic                              auto_clr_i,
  input  logic                              stat_wr_i,
  input  logic                              stat_wdata_i,
  input  logic                              stat_rd_i,
  output logic                              flag_o,
  output logic                              irq_no
);
  logic [NUM_FIELDS-1:0] fld_en, fld_eq;
  logic active, hit, clr_req;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    alarm_field_cmp #(.W(BYTE_W)) u_cmp (
      .alm_i  (alm_i[f]),
      .time_i (time_i[f]),
      .en_o   (fld_en[f]),
      .eq_o   (fld_eq[f])
    );
  end

  assign active  = alarm_en_i && !fout_en_i;
  assign hit     = tick_i && active && (|fld_en) && (&(fld_eq | ~fld_en));
  assign clr_req = (stat_wr_i && !stat_wdata_i) || (stat_rd_i && auto_clr_i);

  alarm_flag_ctrl u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .clr_i  (clr_req),
    .flag_o (flag_o)
  );

  alarm_irq_gen #(.PULSE_LEN(PULSE_LEN)) u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trig_i       (hit),
    .pulse_mode_i (pulse_mode_i),
    .flag_i       (flag_o),
    .irq_no       (irq_no)
  );

  p_inactive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !flag_o) |=> !flag_o);
  p_no_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !flag_o) |=> !flag_o);
endmodule

// File: tb/alarm_match_ctrl_test.sv
`timescale 1ns/1ps
module alarm_match_ctrl_test;
  localparam int PL = 16;

  logic clk = 0, rst_n = 0;
  logic tick = 0, aen = 0, fen = 0, pmode = 0, aclr = 0;
  logic swr = 0, swd = 0, srd = 0;
  logic [5:0][7:0] tm = '0, alm = '0;
  logic flag, irq_n;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  int ref_flag = 0, ref_cnt = 0;

  always #2 clk = ~clk;

  alarm_match_ctrl #(.PULSE_LEN(PL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .time_i(tm), .alm_i(alm),
    .alarm_en_i(aen), .fout_en_i(fen), .pulse_mode_i(pmode), .auto_clr_i(aclr),
    .stat_wr_i(swr), .stat_wdata_i(swd), .stat_rd_i(srd),
    .flag_o(flag), .irq_no(irq_n)
  );

  function automatic bit ref_match();
    int n_en = 0;
    if (!tick || !aen || fen) return 0;
    for (int f = 0; f < 6; f++) begin
      if (alm[f][7]) begin
        n_en++;
        if (alm[f][6:0] != tm[f][6:0]) return 0;
      end
    end
    return n_en > 0;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      bit h;
      h = ref_match();
      if (h) ref_flag = 1;
      else if ((swr && !swd) || (srd && aclr)) ref_flag = 0;
      if (h && pmode) ref_cnt = PL;
      else if (ref_cnt > 0) ref_cnt--;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_irq;
      exp_irq = pmode ? (ref_cnt == 0) : !ref_flag;
      chk(flag == ref_flag[0], {cur_req, " flag"}, flag, ref_flag);
      chk(irq_n == exp_irq[0], {cur_req, " irq"}, irq_n, exp_irq);
    end
  end

  task automatic do_tick();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  task automatic wr_stat(input logic v);
    @(negedge clk) begin swr = 1; swd = v; end
    @(negedge clk) swr = 0;
  endtask

  task automatic rd_stat();
    @(negedge clk) srd = 1;
    @(negedge clk) srd = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    #9;
    chk(flag == 0, "R1 reset flag", flag, 0);
    chk(irq_n == 1, "R1 reset irq", irq_n, 1);
    @(negedge clk) rst_n = 1;
    repeat (2) @(negedge clk);

    // R2: minute 30 / hour 11 enabled, other fields disabled
    cur_req = "R2";
    aen = 1;
    alm[alarm_pkg::FLD_MIN]  = 8'hB0;
    alm[alarm_pkg::FLD_HOUR] = 8'h91;
    alm[alarm_pkg::FLD_SEC]  = 8'h15;
    tm[alarm_pkg::FLD_HOUR]  = 8'h11;
    tm[alarm_pkg::FLD_MIN]   = 8'h29;
    tm[alarm_pkg::FLD_SEC]   = 8'h42;
    do_tick();
    chk(flag == 0, "R3 mismatch no flag", flag, 0);
    tm[alarm_pkg::FLD_MIN] = 8'hB0;  // time bit 7 ignored
    @(negedge clk);
    chk(flag == 0, "R3 no tick no flag", flag, 0);
    do_tick();
    chk(flag == 1, "R2 match sets flag", flag, 1);
    chk(irq_n == 0, "R5 latched irq low", irq_n, 0);
    repeat (5) @(negedge clk);
    chk(irq_n == 0, "R5 irq held low", irq_n, 0);

    // R7
    cur_req = "R7";
    wr_stat(1);
    chk(flag == 1, "R7 write 1 no effect", flag, 1);
    wr_stat(0);
    chk(flag == 0, "R7 write 0 clears", flag, 0);
    chk(irq_n == 1, "R5 irq released", irq_n, 1);

    // R8
    cur_req = "R8";
    do_tick();
    rd_stat();
    chk(flag == 1, "R8 read no autoclear", flag, 1);
    aclr = 1;
    rd_stat();
    chk(flag == 0, "R8 read autoclears", flag, 0);
    aclr = 0;

    // R4
    cur_req = "R4";
    aen = 0;
    do_tick();
    chk(flag == 0, "R4 alarm disabled", flag, 0);
    aen = 1; fen = 1;
    do_tick();
    chk(flag == 0, "R4 fout blocks", flag, 0);
    fen = 0;

    // R3: nothing enabled never matches
    cur_req = "R3";
    for (int f = 0; f < 6; f++) alm[f] = {1'b0, tm[f][6:0]};
    do_tick();
    chk(flag == 0, "R3 none enabled", flag, 0);

    // all fields enabled
    for (int f = 0; f < 6; f++) alm[f] = {1'b1, tm[f][6:0]};
    do_tick();
    chk(flag == 1, "R3 all fields match", flag, 1);
    wr_stat(0);

    // R9: match and clear in same cycle
    cur_req = "R9";
    @(negedge clk) begin tick = 1; swr = 1; swd = 0; end
    @(negedge clk) begin tick = 0; swr = 0; end
    chk(flag == 1, "R9 set beats clear", flag, 1);
    wr_stat(0);

    // R6 pulsed mode
    cur_req = "R6";
    pmode = 1;
    begin
      int low = 0;
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      for (int i = 0; i < PL + 4; i++) begin
        if (!irq_n) low++;
        @(negedge clk);
      end
      chk(low == PL, "R6 pulse length", low, PL);
      chk(irq_n == 1, "R6 pulse ends", irq_n, 1);
    end
    begin
      int low = 0;
      do_tick();
      repeat (5) @(negedge clk);
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      for (int i = 0; i < PL + 4; i++) begin
        if (!irq_n) low++;
        @(negedge clk);
      end
      chk(low == PL, "R6 retrigger full length", low, PL);
    end
    chk(flag == 1, "R6 flag set in pulse mode", flag, 1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule